// File: doc/BRIEF.md
# Host Command Front End with Refresh Interval Timer

This block sits between a host processor and the command stage of a DRAM controller. On each rising clock edge where the host presents a valid command while the block is idle, it captures a 3-bit operation code and an address. It turns the code into a one-hot request and holds that request until the command stage acknowledges it. While a command is held, the block reports itself busy and accepts nothing new.

Beside the decoder runs a refresh interval timer. It is a down-counter whose period the host writes. Each time the counter expires, the timer reloads itself and raises a sticky refresh request, which the command stage clears with its own acknowledge. The timer runs whatever the host is doing. A period of zero stops it.

Top module: `hostcmd_refresh_front`

## Requirements
- R1: While rst_n is low and on the first cycle after release, host_ready is 1, req_onehot is all zero and refresh_req is 0. The period register and the counter both start from the parameter REF_DEFAULT.
- R2: When host_valid is 1 and host_ready is 1 at a rising edge, the code is captured. From the next cycle, req_onehot has exactly one bit set: code 000 (no-op) sets bit 0, 001 (read, auto-precharge) bit 1, 010 (write, auto-precharge) bit 2, 011 (refresh) bit 3, 100 (precharge) bit 4, and 101 (mode load) bit 5.
- R3: Codes 110 and 111 are captured as the no-op, so they set bit 0.
- R4: A captured command keeps req_onehot and req_addr unchanged, with host_ready at 0, until a cycle with cmd_ack at 1. After that edge, host_ready is 1 and req_onehot is zero.
- R5: host_valid together with any code or address is ignored while a command is pending.
- R6: cmd_ack is ignored when no command is pending.
- R7: With a nonzero period P and no period write, refresh_req is set on every (P+1)-th edge, when the counter reaches zero and reloads. It stays at 1 until an edge with refresh_ack at 1.
- R8: A rising edge with period_we at 1 loads period_wdata into both the period register and the counter. Counting resumes from that value on the next edge.
- R9: A period of zero stops the counter and sets no new refresh request. A request that was already set stays until it is acknowledged.
- R10: If the counter expires on the same edge where refresh_ack is 1, refresh_req ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_valid | input | 1 | Host presents a command |
| host_cmd | input | 3 | Host operation code |
| host_addr | input | ADDR_W | Host address carried with the command |
| host_ready | output | 1 | No command pending; a valid command is taken this edge |
| cmd_ack | input | 1 | Command stage has taken the pending request |
| req_onehot | output | 6 | One-hot decoded request, zero when idle |
| req_addr | output | ADDR_W | Address of the pending request |
| period_we | input | 1 | Write strobe for the refresh period register |
| period_wdata | input | CNT_W | New refresh period |
| refresh_req | output | 1 | Sticky automatic refresh request |
| refresh_ack | input | 1 | Command stage has serviced the refresh |

## Verification
The hardest case to reach is the timer expiring on the very edge where refresh_ack is high. With the default period this happens only once every few dozen cycles. The bench writes a short period and then holds refresh_ack high over a long stretch, so that several expiries fall inside acknowledged cycles. It also writes a zero period while a request is outstanding, to show that the request stays set but does not come back once it is cleared. Host traffic with busy-time retries and stray acknowledges runs during both phases.

// File: rtl/hcf_pkg.sv
package hcf_pkg;
  localparam int CMD_W   = 3;
  localparam int NUM_OPS = 6;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP    = 3'd0,
    OP_READA  = 3'd1,
    OP_WRITEA = 3'd2,
    OP_REFR   = 3'd3,
    OP_PRECH  = 3'd4,
    OP_LMODE  = 3'd5
  } host_op_e;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_PEND = 1'b1
  } trk_state_e;
endpackage

// File: rtl/hcf_cmd_decode.sv
module hcf_cmd_decode
  import hcf_pkg::*;
(
  input  logic [CMD_W-1:0]   code,
  output logic [NUM_OPS-1:0] onehot
);
  logic [NUM_OPS-1:0] raw;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
    assign raw[i] = (code == CMD_W'(i));
  end

  // Codes outside the table fall back to the no-op slot.
  always_comb begin
    onehot    = raw;
    onehot[0] = raw[0] | ~(|raw);
  end

  always_comb begin
    assert_decode_onehot_R3: assert ($onehot(onehot));
  end
endmodule

// File: rtl/hcf_cmd_track.sv
module hcf_cmd_track
  import hcf_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic [NUM_OPS-1:0] dec_onehot,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               cmd_ack,
  output logic               host_ready,
  output logic [NUM_OPS-1:0] req_onehot,
  output logic [ADDR_W-1:0]  req_addr
);
  trk_state_e         state_q, state_d;
  logic [NUM_OPS-1:0] op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               load_en;

  assign load_en = (state_q == TRK_IDLE) && host_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TRK_IDLE: if (host_valid) state_d = TRK_PEND;
      TRK_PEND: if (cmd_ack)    state_d = TRK_IDLE;
      default:                  state_d = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
    end else if (load_en) begin
      op_q   <= dec_onehot;
      addr_q <= host_addr;
    end
  end

  assign host_ready = (state_q == TRK_IDLE);
  assign req_onehot = (state_q == TRK_PEND) ? op_q : '0;
  assign req_addr   = addr_q;

  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_onehot) && (host_ready || $onehot(req_onehot)));

  assert_hold_until_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && !cmd_ack) |=> (!host_ready && $stable(req_onehot) && $stable(req_addr)));

  assert_release_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_ready && cmd_ack) |=> (host_ready && req_onehot == '0));

  assert_idle_ack_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ready && !host_valid) |=> host_ready);
endmodule

// File: rtl/hcf_refresh_timer.sv
module hcf_refresh_timer #(
  parameter int          CNT_W       = 16,
  parameter logic [15:0] REF_DEFAULT = 16'd1560
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             refresh_ack,
  output logic             refresh_req
);
  localparam logic [CNT_W-1:0] PER_RST = CNT_W'(REF_DEFAULT);

  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             enabled, expire;

  assign enabled = (per_q != '0);
  assign expire  = enabled && (cnt_q == '0) && !period_we;

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    if (period_we) begin
      per_d = period_wdata;
      cnt_d = period_wdata;
    end else if (enabled) begin
      cnt_d = (cnt_q == '0) ? per_q : cnt_q - 1'b1;
    end
    req_d = expire | (req_q & ~refresh_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PER_RST;
      cnt_q <= PER_RST;
      req_q <= 1'b0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign refresh_req = req_q;

  assert_req_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  assert_zero_period_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == '0 && !period_we && !refresh_req) |=> !refresh_req);

  assert_write_reloads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    period_we |=> (cnt_q == $past(period_wdata) && per_q == $past(period_wdata)));

  assert_counter_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
endmodule

// File: rtl/hostcmd_refresh_front.sv
module hostcmd_refresh_front
  import hcf_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          CNT_W       = 16,
  parameter logic [15:0] REF_DEFAULT = 16'd1560
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic [CMD_W-1:0]   host_cmd,
  input  logic [ADDR_W-1:0]  host_addr,
  output logic               host_ready,
  input  logic               cmd_ack,
  output logic [NUM_OPS-1:0] req_onehot,
  output logic [ADDR_W-1:0]  req_addr,
  input  logic               period_we,
  input  logic [CNT_W-1:0]   period_wdata,
  output logic               refresh_req,
  input  logic               refresh_ack
);
  logic [NUM_OPS-1:0] dec_onehot;

  hcf_cmd_decode u_decode (
    .code   (host_cmd),
    .onehot (dec_onehot)
  );

  hcf_cmd_track #(.ADDR_W(ADDR_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .dec_onehot (dec_onehot),
    .host_addr  (host_addr),
    .cmd_ack    (cmd_ack),
    .host_ready (host_ready),
    .req_onehot (req_onehot),
    .req_addr   (req_addr)
  );

  hcf_refresh_timer #(.CNT_W(CNT_W), .REF_DEFAULT(REF_DEFAULT)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_we    (period_we),
    .period_wdata (period_wdata),
    .refresh_ack  (refresh_ack),
    .refresh_req  (refresh_req)
  );

  assert_ready_on_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (host_ready && req_onehot == '0 && !refresh_req));
endmodule

// File: tb/hostcmd_refresh_front_tb.sv
module hostcmd_refresh_front_tb;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int DEFP   = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_valid = 1'b0;
  logic [2:0]        host_cmd = '0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              host_ready;
  logic              cmd_ack = 1'b0;
  logic [5:0]        req_onehot;
  logic [ADDR_W-1:0] req_addr;
  logic              period_we = 1'b0;
  logic [CNT_W-1:0]  period_wdata = '0;
  logic              refresh_req;
  logic              refresh_ack = 1'b0;

  always #2.5 clk = ~clk;

  hostcmd_refresh_front #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REF_DEFAULT(16'(DEFP))) u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_cmd(host_cmd),
    .host_addr(host_addr), .host_ready(host_ready), .cmd_ack(cmd_ack),
    .req_onehot(req_onehot), .req_addr(req_addr), .period_we(period_we),
    .period_wdata(period_wdata), .refresh_req(refresh_req), .refresh_ack(refresh_ack)
  );

  int checks = 0;
  int fails  = 0;
  string phase = "R1 reset";
  bit done = 1'b0;

  // Behavioural reference: pending flag, held op index and address, timer state.
  int m_pend, m_op, m_addr, m_per, m_cnt, m_req, fire;
  initial begin
    m_pend = 0; m_op = 0; m_addr = 0; m_per = DEFP; m_cnt = DEFP; m_req = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_op = 0; m_addr = 0; m_per = DEFP; m_cnt = DEFP; m_req = 0;
    end else begin
      if (m_pend == 0) begin
        if (host_valid) begin
          m_pend = 1;
          m_op   = (host_cmd > 5) ? 0 : int'(host_cmd);
          m_addr = int'(host_addr);
        end
      end else if (cmd_ack) begin
        m_pend = 0;
      end
      fire = 0;
      if (period_we) begin
        m_per = int'(period_wdata);
        m_cnt = int'(period_wdata);
      end else if (m_per != 0) begin
        if (m_cnt == 0) begin
          fire  = 1;
          m_cnt = m_per;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      if (fire) m_req = 1;
      else if (refresh_ack) m_req = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", tag, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        check("R1 host_ready", int'(host_ready), 1);
        check("R1 req_onehot", int'(req_onehot), 0);
        check("R1 refresh_req", int'(refresh_req), 0);
      end else begin
        check("R4 host_ready", int'(host_ready), m_pend ? 0 : 1);
        check("R2/R3 req_onehot", int'(req_onehot), m_pend ? (1 << m_op) : 0);
        if (m_pend) check("R4 req_addr", int'(req_addr), m_addr);
        check("R7 refresh_req", int'(refresh_req), m_req);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    host_valid = 1'b0; cmd_ack = 1'b0; period_we = 1'b0; refresh_ack = 1'b0;
  endtask

  task automatic issue(input logic [2:0] code, input int addr, input int wait_cyc);
    host_valid = 1'b1; host_cmd = code; host_addr = ADDR_W'(addr);
    tick();
    // R5: keep presenting other commands while the first is pending
    phase = "R5 busy host_valid";
    host_cmd = code ^ 3'b101; host_addr = ADDR_W'(addr ^ 'hFFFF);
    for (int k = 0; k < wait_cyc; k++) tick();
    host_valid = 1'b0;
    phase = "R4 ack";
    cmd_ack = 1'b1;
    tick();
    cmd_ack = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R2 and R3: every code, including the two undefined ones
    for (int c = 0; c < 8; c++) begin
      phase = (c > 5) ? "R3 undefined code" : "R2 decode";
      issue(3'(c), 'h1000 + c * 'h111, 1 + c % 3);
      tick();
    end

    // R6: acknowledge with nothing pending
    phase = "R6 idle ack";
    cmd_ack = 1'b1;
    repeat (3) tick();
    cmd_ack = 1'b0;

    // Back-to-back capture straight after an ack
    phase = "R4 back to back";
    host_valid = 1'b1; host_cmd = 3'd1; host_addr = 'hABCDE;
    tick();
    cmd_ack = 1'b1; host_cmd = 3'd2; host_addr = 'h12345;
    tick();
    cmd_ack = 1'b0;
    tick();
    host_valid = 1'b0; cmd_ack = 1'b1;
    tick();
    cmd_ack = 1'b0;

    // R7: default-period expiry, late acknowledge
    phase = "R7 default period";
    repeat (30) tick();
    refresh_ack = 1'b1; tick(); refresh_ack = 1'b0;

    // R8: write a short period mid-count
    phase = "R8 period write";
    period_we = 1'b1; period_wdata = 16'd4; tick(); period_we = 1'b0;
    repeat (12) tick();

    // R10: hold acknowledge over several expiries
    phase = "R10 ack on expiry";
    refresh_ack = 1'b1;
    repeat (17) tick();
    refresh_ack = 1'b0;
    repeat (3) tick();

    // R9: zero period with a request outstanding
    phase = "R9 zero period";
    period_we = 1'b1; period_wdata = 16'd0; tick(); period_we = 1'b0;
    repeat (25) tick();
    refresh_ack = 1'b1; tick(); refresh_ack = 1'b0;
    repeat (30) tick();

    // Mixed random traffic with a running timer
    phase = "R7 mixed traffic";
    period_we = 1'b1; period_wdata = 16'd6; tick(); period_we = 1'b0;
    for (int n = 0; n < 600; n++) begin
      host_valid   = ($urandom % 3) == 0;
      host_cmd     = 3'($urandom);
      host_addr    = ADDR_W'($urandom);
      cmd_ack      = ($urandom % 4) == 0;
      refresh_ack  = ($urandom % 5) == 0;
      period_we    = ($urandom % 97) == 0;
      period_wdata = 16'($urandom % 9);
      tick();
    end
    idle_inputs();
    repeat (5) tick();
    finish_run();
  end
endmodule